// File: doc/BRIEF.md
# Multi-Mode Byte DMA Channel

A single DMA channel that copies a programmed number of bytes between a wide memory bus (an 8-bit bank plus a 16-bit address) and a narrow register port addressed by an 8-bit number. Software-side configuration is presented on plain inputs. A one-cycle start pulse latches it and launches the transfer. The channel then walks the memory address up, down or not at all. Each byte goes to, or comes from, a port register at a programmed base plus a small offset. That offset follows a repeating pattern chosen by a 3-bit mode.

Both buses use fixed-timing strobes. A read strobe is answered by read data on the following cycle, and a write strobe carries its data in the same cycle. Every transfer spends one lead slot of 8 clocks and then one 8-clock slot per byte. An abort input lets a higher-priority line-synchronised engine that claims the same channel kill the transfer at once. When that happens, the remaining count and the current address stay where they stopped.

Top module: `byte_dma_channel`

## Requirements
- R1: The port address of byte k (k counted from 0 within a transfer) is base + offset, modulo 256. The offset is 0 for modes 0, 2 and 6. It is k mod 2 for modes 1 and 5. It is (k mod 4) div 2 for modes 3 and 7, giving 0,0,1,1. It is k mod 4 for mode 4. The pattern restarts at k = 0 for every new transfer, including one that follows an abort.
- R2: A programmed count of 0 moves 65536 bytes. After j bytes, cur_count_o reads 65536 - j.
- R3: After each byte the low 16 address bits change. They stay the same when hold_addr_i was 1 at start. Otherwise they decrease by 1 when down_i was 1, and increase by 1 when it was 0, wrapping modulo 65536. The bank on mem_addr_o[23:16] never changes.
- R4: With to_mem_i = 0 the channel reads memory and writes the same byte to the port. With to_mem_i = 1 it reads the port and writes the same byte to memory. Both directions use the same offset pattern.
- R5: The first 8 cycles after start form a lead slot with no strobes. Each byte then has an 8-cycle slot. The read strobe is in slot cycle 0, the data is taken from the read-data input in slot cycle 1, and the write strobe is in slot cycle 2.
- R6: At the end of each byte slot, cur_count_o decrements by one and cur_addr_o takes its next value. Both load from count_i and addr_i when the start is accepted.
- R7: abort_i high at a clock edge while busy clears busy_o from the next cycle. It raises no done pulse, issues no further strobes, and leaves cur_count_o and cur_addr_o at their partial values.
- R8: When the bank is 0x7E or 0x7F, the port base is 0x80 and to_mem_i = 0, no strobe is issued on either bus. The timing and the count and address updates are still as in R5 and R6.
- R9: busy_o is high from the cycle after an accepted start until the transfer ends. done_o is a single-cycle pulse in the first cycle after the last byte slot, and busy_o is low in that cycle.
- R10: A start pulse while busy is ignored, together with the configuration inputs presented with it.
- R11: After reset, busy_o, done_o, all strobes, cur_count_o and cur_addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| mode_i | input | 3 | Port offset pattern select |
| to_mem_i | input | 1 | 0: memory to port, 1: port to memory |
| hold_addr_i | input | 1 | 1: memory address does not move |
| down_i | input | 1 | 1: memory address decrements |
| bank_i | input | 8 | Memory bank |
| addr_i | input | 16 | Starting memory address |
| port_base_i | input | 8 | Port register base |
| count_i | input | 16 | Byte count, 0 means 65536 |
| abort_i | input | 1 | Kill the running transfer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Memory address (bank and offset) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after strobe |
| port_rd_o | output | 1 | Port read strobe |
| port_wr_o | output | 1 | Port write strobe |
| port_addr_o | output | 8 | Port register address |
| port_wdata_o | output | 8 | Port write data |
| port_rdata_i | input | 8 | Port read data, one cycle after strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion pulse |
| cur_addr_o | output | 16 | Current memory address |
| cur_count_o | output | 16 | Remaining byte count |

## Verification
The assertions assume that the reset is applied before the first edge and that start_i and abort_i change only between clock edges. They also assume that the read data on each bus answers a strobe exactly one cycle later. The bench drives every control input on the falling edge. Its memory and port models return data through a register clocked by the same strobes, so that latency always holds. Aborts are raised only while the channel is busy. Starts issued during a busy period are made deliberately, to exercise the ignore rule.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  localparam int MEM_OFS_W = 16;
  localparam int PORT_W    = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_MOVE} bdma_state_t;

  // Port register offset for a given mode and pattern phase.
  function automatic logic [1:0] port_offset(input logic [2:0] mode, input logic [1:0] ph);
    case (mode)
      3'd1, 3'd5: port_offset = {1'b0, ph[0]};
      3'd3, 3'd7: port_offset = {1'b0, ph[1]};
      3'd4:       port_offset = ph;
      default:    port_offset = 2'd0;
    endcase
  endfunction

  // Next memory offset for the chosen stepping rule.
  function automatic logic [MEM_OFS_W-1:0] next_ofs(input logic [MEM_OFS_W-1:0] a,
                                                    input logic hold, input logic down);
    if (hold)      next_ofs = a;
    else if (down) next_ofs = a - 1'b1;
    else           next_ofs = a + 1'b1;
  endfunction

  // Transfer that would make the work memory read and write itself.
  function automatic logic self_loop(input logic [7:0] bank, input logic [PORT_W-1:0] base,
                                     input logic to_mem);
    self_loop = ((bank == 8'h7E) || (bank == 8'h7F)) && (base == 8'h80) && !to_mem;
  endfunction
endpackage

// File: rtl/bdma_slot_timer.sv
module bdma_slot_timer #(
  parameter int SLOT = 8,
  localparam int SW = $clog2(SLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic [SW-1:0] pos,
  output logic          last
);
  assign last = (pos == SW'(SLOT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (clear) pos <= '0;
    else if (run)   pos <= last ? '0 : pos + 1'b1;
  end

  // R5
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && last) |=> (pos == '0));
endmodule

// File: rtl/bdma_walker.sv
module bdma_walker
  import bdma_pkg::*;
#(
  parameter int AW = MEM_OFS_W,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          clear_ph,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_count,
  input  logic          hold,
  input  logic          down,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic [1:0]    phase,
  output logic          final_byte
);
  assign final_byte = (cur_count == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_count <= '0;
      phase     <= '0;
    end else if (load) begin
      cur_addr  <= ld_addr;
      cur_count <= ld_count;
      phase     <= '0;
    end else begin
      if (step) begin
        cur_addr  <= next_ofs(cur_addr, hold, down);
        cur_count <= cur_count - 1'b1;
      end
      if (clear_ph)  phase <= '0;
      else if (step) phase <= phase + 1'b1;
    end
  end

  // R6
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_count == $past(cur_count) - 1'b1));
  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && hold) |=> $stable(cur_addr));
endmodule

// File: rtl/byte_dma_channel.sv
module byte_dma_channel
  import bdma_pkg::*;
#(
  parameter int SLOT = 8,
  parameter int CW   = 16,
  localparam int AW  = MEM_OFS_W,
  localparam int BW  = PORT_W,
  localparam int SW  = $clog2(SLOT),
  localparam int RD_AT  = 0,
  localparam int CAP_AT = 1,
  localparam int WR_AT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic          to_mem_i,
  input  logic          hold_addr_i,
  input  logic          down_i,
  input  logic [7:0]    bank_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] port_base_i,
  input  logic [CW-1:0] count_i,
  input  logic          abort_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [23:0]   mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          port_rd_o,
  output logic          port_wr_o,
  output logic [BW-1:0] port_addr_o,
  output logic [7:0]    port_wdata_o,
  input  logic [7:0]    port_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_count_o
);
  bdma_state_t   state_q;
  logic [2:0]    mode_q;
  logic          to_mem_q, hold_q, down_q, blocked_q, done_q;
  logic [7:0]    bank_q, data_q;
  logic [BW-1:0] base_q;
  logic [SW-1:0] pos;
  logic          slot_last, final_byte;
  logic [1:0]    phase;

  // Named internal events.
  logic accept, abort_hit, byte_end, finish, in_move, rd_slot, wr_slot, cap_slot;
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign abort_hit = (state_q != ST_IDLE) && abort_i;
  assign in_move   = (state_q == ST_MOVE);
  assign byte_end  = in_move && slot_last && !abort_i;
  assign finish    = byte_end && final_byte;
  assign rd_slot   = in_move && (pos == SW'(RD_AT)) && !blocked_q;
  assign cap_slot  = in_move && (pos == SW'(CAP_AT));
  assign wr_slot   = in_move && (pos == SW'(WR_AT)) && !blocked_q;

  bdma_slot_timer #(.SLOT(SLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept || abort_hit),
    .run(state_q != ST_IDLE), .pos(pos), .last(slot_last));

  bdma_walker #(.AW(AW), .CW(CW)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(byte_end),
    .clear_ph(finish || abort_hit), .ld_addr(addr_i), .ld_count(count_i),
    .hold(hold_q), .down(down_q), .cur_addr(cur_addr_o), .cur_count(cur_count_o),
    .phase(phase), .final_byte(final_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      to_mem_q  <= 1'b0;
      hold_q    <= 1'b0;
      down_q    <= 1'b0;
      bank_q    <= '0;
      base_q    <= '0;
      blocked_q <= 1'b0;
      done_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q   <= ST_LEAD;
        mode_q    <= mode_i;
        to_mem_q  <= to_mem_i;
        hold_q    <= hold_addr_i;
        down_q    <= down_i;
        bank_q    <= bank_i;
        base_q    <= port_base_i;
        blocked_q <= self_loop(bank_i, port_base_i, to_mem_i);
      end else if (abort_hit) begin
        state_q <= ST_IDLE;
      end else begin
        if (state_q == ST_LEAD && slot_last) state_q <= ST_MOVE;
        if (finish) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
      if (cap_slot) data_q <= to_mem_q ? port_rdata_i : mem_rdata_i;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign mem_rd_o     = rd_slot && !to_mem_q;
  assign port_wr_o    = wr_slot && !to_mem_q;
  assign port_rd_o    = rd_slot && to_mem_q;
  assign mem_wr_o     = wr_slot && to_mem_q;
  assign mem_addr_o   = {bank_q, cur_addr_o};
  assign port_addr_o  = base_q + BW'(port_offset(mode_q, phase));
  assign mem_wdata_o  = data_q;
  assign port_wdata_o = data_q;

  // R7
  abort_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!busy_o && !done_o && $stable(cur_count_o)));
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R9
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(abort_i)) |-> done_o);
  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |-> !(mem_rd_o || mem_wr_o || port_rd_o || port_wr_o));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(mode_q) && $stable(bank_q) && $stable(base_q)));
  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !accept) |=> $stable(mem_addr_o[23:16]));
endmodule

// File: tb/byte_dma_channel_tb.sv
module byte_dma_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, to_mem_i = 0, hold_addr_i = 0, down_i = 0, abort_i = 0;
  logic [2:0] mode_i = 0;
  logic [7:0] bank_i = 0, port_base_i = 0;
  logic [15:0] addr_i = 0, count_i = 0;
  logic mem_rd_o, mem_wr_o, port_rd_o, port_wr_o, busy_o, done_o;
  logic [23:0] mem_addr_o;
  logic [7:0] mem_wdata_o, port_addr_o, port_wdata_o;
  logic [7:0] mem_rdata_i = 0, port_rdata_i = 0;
  logic [15:0] cur_addr_o, cur_count_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  byte_dma_channel u_dut (.*);

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] port_val(input logic [7:0] a);
    return a * 8'd3 + 8'd1;
  endfunction
  function automatic int pat(input int mode, input int k);
    if (mode == 4) return k % 4;
    if (mode == 1 || mode == 5) return k % 2;
    if (mode == 3 || mode == 7) return (k % 4) / 2;
    return 0;
  endfunction

  // Bus models: registered read data, one cycle after the strobe.
  always @(posedge clk) begin
    mem_rdata_i  <= mem_rd_o ? mem_val(mem_addr_o) : 8'h00;
    port_rdata_i <= port_rd_o ? port_val(port_addr_o) : 8'h00;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated after every edge.
  bit m_busy = 0, m_done = 0, m_blk = 0;
  int m_mode, m_dir, m_fix, m_dec, m_bank, m_base, m_addr = 0, rem = 0, e = 0, nbytes = 0;

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_addr = 0; rem = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin
          m_busy = 1; e = 0; nbytes = 0;
          m_mode = mode_i; m_dir = to_mem_i; m_fix = hold_addr_i; m_dec = down_i;
          m_bank = bank_i; m_base = port_base_i; m_addr = addr_i;
          rem = (count_i == 0) ? 65536 : count_i;
          m_blk = (m_bank == 8'h7E || m_bank == 8'h7F) && m_base == 8'h80 && m_dir == 0;
        end
      end else if (abort_i) begin
        m_busy = 0;
      end else if (e >= 8 && (e - 8) % 8 == 7) begin
        rem = rem - 1; nbytes++;
        m_addr = (m_addr + (m_fix ? 0 : (m_dec ? -1 : 1)) + 65536) % 65536;
        if (rem == 0) begin m_busy = 0; m_done = 1; end
        else e++;
      end else e++;

      begin
        bit xr_mem, xw_mem, xr_port, xw_port;
        int s, bexp;
        s = (e - 8) % 8;
        xr_mem = 0; xw_mem = 0; xr_port = 0; xw_port = 0;
        if (m_busy && e >= 8 && !m_blk) begin
          xr_mem  = (s == 0) && m_dir == 0;
          xw_port = (s == 2) && m_dir == 0;
          xr_port = (s == 0) && m_dir == 1;
          xw_mem  = (s == 2) && m_dir == 1;
        end
        bexp = (m_base + pat(m_mode, nbytes)) % 256;
        // R9 busy and done timing
        chk(busy_o == m_busy && done_o == m_done, "R9 busy/done",
            {busy_o, done_o}, {m_busy, m_done});
        // R5 and R8 strobes (R4 direction)
        chk({mem_rd_o, mem_wr_o, port_rd_o, port_wr_o} == {xr_mem, xw_mem, xr_port, xw_port},
            m_blk ? "R8 strobes" : "R5/R4 strobes",
            {mem_rd_o, mem_wr_o, port_rd_o, port_wr_o}, {xr_mem, xw_mem, xr_port, xw_port});
        // R6 running count and address
        chk(cur_count_o == rem[15:0] && cur_addr_o == m_addr[15:0], "R6 count/addr",
            {cur_count_o, cur_addr_o}, {rem[15:0], m_addr[15:0]});
        if (xr_mem || xw_mem)
          // R3 memory address
          chk(mem_addr_o == {m_bank[7:0], m_addr[15:0]}, "R3 mem addr",
              mem_addr_o, {m_bank[7:0], m_addr[15:0]});
        if (xr_port || xw_port)
          // R1 port offset pattern
          chk(port_addr_o == bexp[7:0], "R1 port addr", port_addr_o, bexp);
        if (xw_port)
          // R4 memory-to-port data
          chk(port_wdata_o == mem_val({m_bank[7:0], m_addr[15:0]}), "R4 port data",
              port_wdata_o, mem_val({m_bank[7:0], m_addr[15:0]}));
        if (xw_mem)
          // R4 port-to-memory data
          chk(mem_wdata_o == port_val(bexp[7:0]), "R4 mem data",
              mem_wdata_o, port_val(bexp[7:0]));
      end
    end
  end

  task automatic launch(input int mode, input int dir, input int fix, input int dec,
                        input int bank, input int addr, input int base, input int cnt);
    @(negedge clk);
    mode_i = mode[2:0]; to_mem_i = dir[0]; hold_addr_i = fix[0]; down_i = dec[0];
    bank_i = bank[7:0]; addr_i = addr[15:0]; port_base_i = base[7:0]; count_i = cnt[15:0];
    start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic run(input int mode, input int dir, input int fix, input int dec,
                     input int bank, input int addr, input int base, input int cnt);
    int ea;
    launch(mode, dir, fix, dec, bank, addr, base, cnt);
    while (busy_o) @(negedge clk);
    ea = (addr + cnt * (fix ? 0 : (dec ? -1 : 1)) + 65536 * 4) % 65536;
    // R6 final count
    chk(cur_count_o == 16'h0, "R6 final count", cur_count_o, 0);
    // R3 final address
    chk(cur_addr_o == ea[15:0], "R3 final addr", cur_addr_o, ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({busy_o, done_o, mem_rd_o, mem_wr_o, port_rd_o, port_wr_o} == 6'b0, "R11 reset flags",
        {busy_o, done_o, mem_rd_o, mem_wr_o, port_rd_o, port_wr_o}, 0);
    chk(cur_count_o == 0 && cur_addr_o == 0, "R11 reset regs", {cur_count_o, cur_addr_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(0, 0, 0, 0, 8'h12, 16'h0100, 8'h18, 3);
    run(1, 0, 0, 0, 8'h00, 16'h2000, 8'h18, 5);
    run(3, 0, 0, 1, 8'h40, 16'h0050, 8'h30, 6);
    run(4, 1, 1, 0, 8'h01, 16'h4000, 8'h10, 5);
    run(7, 1, 0, 0, 8'h7F, 16'h8000, 8'h20, 4);
    run(5, 0, 0, 0, 8'h03, 16'h0000, 8'hFF, 4);
    run(2, 1, 0, 1, 8'h05, 16'h0003, 8'h22, 2);
    run(6, 0, 1, 0, 8'h06, 16'h1234, 8'h04, 2);
    // R3 wrap both ways
    run(0, 0, 0, 0, 8'h10, 16'hFFFE, 8'h00, 3);
    run(0, 1, 0, 1, 8'h10, 16'h0001, 8'h00, 3);
    // R8 blocked combination, both banks; same setup reversed is not blocked
    run(1, 0, 0, 0, 8'h7E, 16'h0200, 8'h80, 3);
    run(0, 0, 0, 1, 8'h7F, 16'h0300, 8'h80, 2);
    run(0, 1, 0, 0, 8'h7E, 16'h0200, 8'h80, 2);

    // R2 and R7: count 0, aborted after three bytes
    launch(4, 0, 0, 0, 8'h05, 16'h1000, 8'h40, 0);
    while (cur_count_o != 16'hFFFD) @(negedge clk);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    chk(busy_o == 0 && done_o == 0, "R7 abort stops", {busy_o, done_o}, 0);
    chk(cur_count_o == 16'd65533, "R2 zero count as 65536", cur_count_o, 65533);
    chk(cur_addr_o == 16'h1003, "R7 partial addr", cur_addr_o, 16'h1003);
    repeat (12) @(negedge clk);
    chk(cur_count_o == 16'd65533, "R7 count held", cur_count_o, 65533);
    // R1 phase restarts after abort
    run(4, 0, 0, 0, 8'h05, 16'h2000, 8'h40, 5);

    // R10 start while busy ignored
    launch(1, 0, 0, 0, 8'h09, 16'h0500, 8'h18, 4);
    repeat (20) @(negedge clk);
    mode_i = 3'd4; bank_i = 8'h22; addr_i = 16'h9999; count_i = 16'd1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (busy_o) @(negedge clk);
    chk(cur_addr_o == 16'h0504, "R10 start ignored", cur_addr_o, 16'h0504);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule